// File: doc/BRIEF.md
# Parallel Port Side Register Interface

This block is one half of a bus-attached parallel I/O adapter. It owns an 8-bit peripheral port and the three CPU-visible registers that drive it: a per-bit direction register, an output register and a control register. The CPU reaches them through a chip select, read and write strobes and a two-bit register select. One data address is shared between the direction and output registers, and a control bit picks which one is reached. Two copies of the block, one with `SIDE` = 0 and one with `SIDE` = 1, make up the full four-register adapter.

The block also keeps the status flag for control line 1. It samples that line through a synchronizer, latches a flag on either edge and clears the flag when the CPU reads the output register. A second flag records events reported by a separate control-line-2 block while that line is an input. An active-low interrupt request is asserted whenever an enabled flag is set.

Top module: `pia_port_side`

## Requirements
- R1: After reset the direction, output and control registers and both flags are zero, `irq_n` is 1 and `port_oe` is all zeros.
- R2: The block responds only to register select `{0,SIDE}` (data) and `{1,SIDE}` (control). Any access with another select, or with `cs` low, changes no register and leaves `rdata` at zero.
- R3: While control bit 2 is 0, a write to the data address loads the direction register and a read returns it. `port_oe` equals the direction register, where 1 means output.
- R4: While control bit 2 is 1, a write to the data address loads the output register, and `port_out` equals that register.
- R5: While control bit 2 is 1, a read of the data address returns the output register on bits whose direction is 1 and the pin level on bits whose direction is 0. The pin level passes through a two-stage synchronizer, so a pin change appears in the read value two clock edges later.
- R6: Any transition of `c1_in`, rising or falling, sets control bit 7 on the third rising clock edge after the change.
- R7: A read of the data address while control bit 2 is 1 clears control bits 7 and 6 at the next edge. A read of the direction register clears neither. A new line-1 edge in the same cycle wins over the clear.
- R8: Control bits 7 and 6 are read-only. A write to the control address updates bits 5 to 0 only, and a control read returns `{flag1, flag2, ctrl[5:0]}`.
- R9: A pulse on `c2_evt` sets control bit 6 only while control bit 5 is 0 (line 2 is an input). While bit 5 is 1, bit 6 reads 0 and the flag is cleared.
- R10: `irq_n` is 0 exactly when (bit 7 is set and control bit 0 is 1) or (bit 6 is set, control bit 3 is 1 and control bit 5 is 0).
- R11: `c2_mode` always equals control bits 5 to 3, for use by the control-line-2 logic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data (zero when not selected for read) |
| port_in | input | WIDTH | Peripheral pin levels |
| port_out | output | WIDTH | Output register to the pins |
| port_oe | output | WIDTH | Per-bit output enable (direction register) |
| c1_in | input | 1 | Control line 1, asynchronous |
| c2_evt | input | 1 | One-cycle event pulse from the control-line-2 logic |
| c2_mode | output | 3 | Control bits 5 to 3 for the control-line-2 logic |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench tests the shared data address in both settings of control bit 2. A design that decoded it backwards would return the direction bits where pin levels belong, and would clear flags on a direction read. Line-1 edges are sent in both polarities and the flag is sampled in the exact edge cycle, so a missing synchronizer stage, or detection of one polarity only, shows up as a flag that is one cycle early or never set. Flag clears are set against new edges in the same cycle, and line-2 events are sent while line 2 is an output, which catches a wrong clear priority and a flag that leaks through in output mode. Writes that try to set the read-only bits and accesses to the other side's addresses catch loose decoding.

// File: rtl/pia_port_side.sv
module pia_port_side #(
  parameter int WIDTH = 8,
  parameter bit SIDE  = 1'b0,
  parameter int SYNC  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             rd,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] port_in,
  output logic [WIDTH-1:0] port_out,
  output logic [WIDTH-1:0] port_oe,
  input  logic             c1_in,
  input  logic             c2_evt,
  output logic [2:0]       c2_mode,
  output logic             irq_n
);

  localparam logic [1:0] DATA_SEL = {1'b0, SIDE};
  localparam logic [1:0] CTRL_SEL = {1'b1, SIDE};

  logic [WIDTH-1:0] ddr_q, out_q;
  logic [5:0]       ctrl_q;
  logic             flag1_q, flag2_q;
  logic [WIDTH-1:0] pin_sync [SYNC];
  logic [SYNC:0]    c1_sync;

  wire data_hit  = cs && addr == DATA_SEL;
  wire ctrl_hit  = cs && addr == CTRL_SEL;
  wire sel_out   = ctrl_q[2];
  wire c1_edge   = c1_sync[SYNC-1] ^ c1_sync[SYNC];
  wire read_clr  = data_hit && rd && sel_out;
  wire c2_input  = !ctrl_q[5];
  wire flag2_vis = flag2_q && c2_input;

  wire [WIDTH-1:0] pins   = pin_sync[SYNC-1];
  wire [WIDTH-1:0] rdback = (out_q & ddr_q) | (pins & ~ddr_q);

  assign port_out = out_q;
  assign port_oe  = ddr_q;
  assign c2_mode  = ctrl_q[5:3];
  assign irq_n    = !((flag1_q && ctrl_q[0]) || (flag2_vis && ctrl_q[3]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c1_sync <= '0;
      for (int i = 0; i < SYNC; i++) pin_sync[i] <= '0;
    end else begin
      c1_sync <= {c1_sync[SYNC-1:0], c1_in};
      pin_sync[0] <= port_in;
      for (int i = 1; i < SYNC; i++) pin_sync[i] <= pin_sync[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ddr_q  <= '0;
      out_q  <= '0;
      ctrl_q <= '0;
    end else if (wr) begin
      if (data_hit && !sel_out) ddr_q <= wdata;
      if (data_hit &&  sel_out) out_q <= wdata;
      if (ctrl_hit)             ctrl_q <= wdata[5:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag1_q <= 1'b0;
      flag2_q <= 1'b0;
    end else begin
      if (c1_edge)       flag1_q <= 1'b1;
      else if (read_clr) flag1_q <= 1'b0;
      if (!c2_input)     flag2_q <= 1'b0;
      else if (c2_evt)   flag2_q <= 1'b1;
      else if (read_clr) flag2_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd && data_hit)
      rdata = sel_out ? rdback : ddr_q;
    else if (rd && ctrl_hit)
      rdata[7:0] = {flag1_q, flag2_vis, ctrl_q};
  end

  assert_ddr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && data_hit && !sel_out) |=> port_oe == $past(wdata));
  assert_out_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && data_hit && sel_out) |=> port_out == $past(wdata));
  assert_ctrl_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ctrl_hit) |=> c2_mode == $past(wdata[5:3]));
  assert_no_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> $stable(port_oe) && $stable(port_out) && $stable(c2_mode));
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (read_clr && !c1_edge) |=> !flag1_q);
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag1_q) |-> $past(c1_sync[SYNC-1] != c1_sync[SYNC]));
  assert_c2_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[5]) |-> !flag2_q);
  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag1_q && !flag2_q) |-> irq_n);

endmodule

// File: tb/sim_pia_port_side.sv
module sim_pia_port_side;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic cs = 0, rd = 0, wr = 0, c1_in = 0, c2_evt = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0, port_in = 0;
  logic [W-1:0] rdata, port_out, port_oe;
  logic [2:0] c2_mode;
  logic irq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_ddr, m_out, m_p1, m_p2;
  logic [5:0] m_ctrl;
  logic m_f1, m_f2, m_c1a, m_c1b, m_c1c;

  pia_port_side u0 (.clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .port_in(port_in), .port_out(port_out), .port_oe(port_oe),
    .c1_in(c1_in), .c2_evt(c2_evt), .c2_mode(c2_mode), .irq_n(irq_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] exp_rdata();
    logic [W-1:0] r = '0;
    if (cs && rd && addr == 2'b00)
      r = m_ctrl[2] ? ((m_out & m_ddr) | (m_p2 & ~m_ddr)) : m_ddr;
    else if (cs && rd && addr == 2'b10)
      r = {m_f1, m_f2 && !m_ctrl[5], m_ctrl};
    return r;
  endfunction

  function automatic logic exp_irq_n();
    return !((m_f1 && m_ctrl[0]) || (m_f2 && !m_ctrl[5] && m_ctrl[3]));
  endfunction

  task automatic model_reset();
    m_ddr = 0; m_out = 0; m_ctrl = 0; m_f1 = 0; m_f2 = 0;
    m_p1 = 0; m_p2 = 0; m_c1a = 0; m_c1b = 0; m_c1c = 0;
  endtask

  task automatic model_step();
    logic edge_c1, clr;
    edge_c1 = m_c1b ^ m_c1c;
    clr = cs && rd && addr == 2'b00 && m_ctrl[2];
    if (edge_c1) m_f1 = 1; else if (clr) m_f1 = 0;
    if (m_ctrl[5]) m_f2 = 0; else if (c2_evt) m_f2 = 1; else if (clr) m_f2 = 0;
    if (cs && wr && addr == 2'b00) begin
      if (m_ctrl[2]) m_out = wdata; else m_ddr = wdata;
    end
    if (cs && wr && addr == 2'b10) m_ctrl = wdata[5:0];
    m_p2 = m_p1; m_p1 = port_in;
    m_c1c = m_c1b; m_c1b = m_c1a; m_c1a = c1_in;
  endtask

  // inputs already driven after a negedge: check outputs, then let a posedge pass
  task automatic cycle(input string rtag);
    #1;
    check(rtag, rdata, exp_rdata());
    check("R10 irq", irq_n, exp_irq_n());
    check("R4 port_out", port_out, m_out);
    check("R3 port_oe", port_oe, m_ddr);
    check("R11 c2_mode", c2_mode, m_ctrl[5:3]);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    cs = 0; rd = 0; wr = 0; c2_evt = 0;
  endtask

  task automatic bus(input logic w, input logic [1:0] a, input logic [W-1:0] d, input string tag);
    cs = 1; rd = !w; wr = w; addr = a; wdata = d;
    cycle(tag);
    idle();
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1;
    check("R1 ddr", port_oe, 0);
    check("R1 out", port_out, 0);
    check("R1 irq", irq_n, 1);
    check("R1 mode", c2_mode, 0);
    cs = 1; rd = 1; addr = 2'b10; #1;
    check("R1 ctrl", rdata, 0);
    idle();
    @(negedge clk);

    // R3 direction load and readback
    bus(1, 2'b00, 8'hF0, "R3 wr");
    bus(0, 2'b00, 0, "R3 ddr read");
    // R8 read-only top bits
    bus(1, 2'b10, 8'hC5, "R8 ctrl wr");
    bus(0, 2'b10, 0, "R8 ctrl read");
    // R4/R5 output register and readback
    bus(1, 2'b00, 8'hA5, "R4 out wr");
    port_in = 8'h3C;
    cycle("R5 idle"); cycle("R5 idle");
    bus(0, 2'b00, 0, "R5 readback");
    // R2 other side and deselected accesses
    bus(1, 2'b01, 8'h77, "R2 other data");
    bus(1, 2'b11, 8'h3F, "R2 other ctrl");
    bus(0, 2'b01, 0, "R2 other read");
    cs = 0; wr = 1; addr = 2'b10; wdata = 8'h3F; cycle("R2 no cs"); idle();
    bus(0, 2'b10, 0, "R2 ctrl unchanged");

    // R6 exact timing of a rising edge, then a falling edge
    c1_in = 1;
    cycle("R6"); cycle("R6");
    #1; check("R6 not yet", irq_n, 1);
    cycle("R6");
    #1; check("R6 flag rise", irq_n, 0);
    // R7 direction read does not clear
    bus(1, 2'b10, 8'h01, "R7 ctrl ddr sel");
    bus(0, 2'b00, 0, "R7 ddr read");
    #1; check("R7 kept", irq_n, 0);
    bus(1, 2'b10, 8'h05, "R7 ctrl out sel");
    bus(0, 2'b00, 0, "R7 clearing read");
    #1; check("R7 cleared", irq_n, 1);
    c1_in = 0;
    cycle("R6"); cycle("R6"); cycle("R6");
    #1; check("R6 flag fall", irq_n, 0);
    bus(0, 2'b00, 0, "R7 clear");
    // R7 edge wins over clear in the same cycle
    c1_in = 1; cycle("R6"); cycle("R6");
    bus(0, 2'b00, 0, "R7 clear vs edge");
    #1; check("R7 edge wins", irq_n, 0);
    bus(0, 2'b00, 0, "R7 clear");

    // R9 line-2 events in output mode are ignored
    bus(1, 2'b10, 8'h3C, "R9 c2 out");
    c2_evt = 1; cycle("R9 evt ignored"); c2_evt = 0;
    bus(0, 2'b10, 0, "R9 bit6 zero");
    bus(1, 2'b10, 8'h0C, "R9 c2 in");
    c2_evt = 1; cycle("R9 evt"); c2_evt = 0;
    bus(0, 2'b10, 0, "R9 bit6 set");
    #1; check("R10 c2 irq", irq_n, 0);
    bus(1, 2'b10, 8'h2C, "R9 to output");
    bus(0, 2'b10, 0, "R9 masked");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      idle();
      if ($urandom_range(0, 15) == 0) c1_in = ~c1_in;
      if ($urandom_range(0, 7) == 0) port_in = W'($urandom);
      c2_evt = ($urandom_range(0, 5) == 0);
      addr = 2'($urandom);
      wdata = W'($urandom);
      if (op < 4) begin cs = 1; rd = 1; end
      else if (op < 8) begin cs = 1; wr = 1; end
      else if (op == 8) begin cs = 0; wr = 1; end
      if (rd && addr == 2'b00) cycle(m_ctrl[2] ? "R5 rnd read" : "R3 rnd read");
      else if (rd && addr == 2'b10) cycle("R8 rnd ctrl read (R6 R7 R9 flags)");
      else cycle("R2 rnd idle read");
    end
    idle();
    cycle("R2 final");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule